// File: doc/BRIEF.md
# Three-Wire Serial Configuration Register Bank

This block receives configuration words over a slow three-wire serial port made of a serial clock, a data line and a latch strobe. All three lines are brought into the system clock domain through synchronizers. The block detects edges on the serial clock and on the strobe. While the strobe is low, every rising serial-clock edge shifts one data bit into a 32-bit frame register, most significant bit first. A rising strobe commits the frame. The low four bits of the frame select a register, and the bit fields of that register are taken from the same frame positions.

The bank keeps settings for a set of clock output channels, for the reference frequency, for the PLL control word and for the loop divider word. Each register starts at a defined default value. Control register 0 carries a soft reset that returns the whole bank to its defaults. Every commit to register 15 raises a one-cycle calibration-start pulse, including a commit that writes the value already stored. The calibration sequence itself is handled elsewhere. There is no readback path.

Top module: `cfg_serial_bank`

## Requirements
- R1: While `ser_le` is low, each rising edge of `ser_clk` shifts the current `ser_data` bit into the least significant end of a 32-bit frame, so the first bit sent ends up as frame bit 31. A rising edge of `ser_le` commits the frame. Serial clock edges while `ser_le` is high shift nothing.
- R2: Frame bits [3:0] hold the target address. A commit to address `CH_BASE+k` loads channel k as follows: mux mode from bits [18:17], enable from bit 16, divide code from bits [15:8] and delay code from bits [7:4]. These appear on `ch_mux[2k+:2]`, `ch_en[k]`, `ch_div[8k+:8]` and `ch_dly[4k+:4]`.
- R3: A commit to address 13 loads `ref_mhz` from frame bits [21:14].
- R4: A commit to address 14 loads the following fields: `fout_en` from bit 28, `glob_out_en` from bit 27, `power_down` from bit 26, `status_mode` from bits [23:20] and `r_div` from bits [19:8].
- R5: A commit to address 15 loads `cp_gain` from bits [31:30], `post_div` from bits [29:26] and `n_div` from bits [25:8].
- R6: A commit to address 15 produces exactly one `cal_start` pulse, one system clock wide, even when the written value equals the stored one. The pulse comes one cycle after the new values appear on the outputs. Commits to any other address produce no pulse.
- R7: A commit to address 0 with bit 31 set returns every field to its default, and the other bits of that frame are ignored. A commit to address 0 with bit 31 clear changes nothing.
- R8: Commits to addresses that hold no fields (1 to 3, 8 to 12, and any address not covered by a channel) leave every output unchanged.
- R9: After `rst_n` is asserted, the outputs take these values: all channels have mux 0, enable 0, divide code 1 and delay 0; `ref_mhz` is 10; `glob_out_en` is 1; `fout_en`, `power_down` and `status_mode` are 0; `r_div` is 10; `cp_gain` is 0; `post_div` is 2; `n_div` is 760; and `cal_start` is low.
- R10: If fewer than 32 bits are sent before a commit, the commit uses the last 32 bits shifted in, carried over from earlier frames, and the bit count is not checked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock, asynchronous to clk |
| ser_data | input | 1 | Serial data, MSB first |
| ser_le | input | 1 | Latch strobe; a rising edge commits the frame |
| ch_mux | output | 2*NUM_CH | Per-channel mux mode |
| ch_en | output | NUM_CH | Per-channel enable |
| ch_div | output | 8*NUM_CH | Per-channel divide code |
| ch_dly | output | 4*NUM_CH | Per-channel delay code |
| ref_mhz | output | 8 | Reference frequency in MHz |
| fout_en | output | 1 | Oscillator output-port enable |
| glob_out_en | output | 1 | Global output enable |
| power_down | output | 1 | Power-down request |
| status_mode | output | 4 | Status pin mode select |
| r_div | output | 12 | Reference divider value |
| cp_gain | output | 2 | Charge-pump gain code |
| post_div | output | 4 | Oscillator post-divider code |
| n_div | output | 18 | Feedback divider value |
| cal_start | output | 1 | One-cycle calibration start pulse |

## Verification
The bench builds the block with `SYNC_STAGES=3`, `NUM_CH=4` and `CH_BASE=4`. With three synchronizer stages, every commit passes through the longer latency path, and each check is made after that latency has elapsed. Four channels at addresses 4 to 7 bring the highest channel into reach, along with address 8 just above it, which holds no fields. Extreme field values, repeated writes to register 15, the reset word with junk in its other bits, and a short frame that reuses bits from the previous word are all driven through the serial pins.

// File: rtl/cfgbank_pkg.sv
`timescale 1ns/1ps
package cfgbank_pkg;
   localparam int FRAME_W = 32;
   localparam int ADDR_W  = 4;

   localparam logic [ADDR_W-1:0] ADR_CTRL = 4'd0;
   localparam logic [ADDR_W-1:0] ADR_REF  = 4'd13;
   localparam logic [ADDR_W-1:0] ADR_PLL  = 4'd14;
   localparam logic [ADDR_W-1:0] ADR_LOOP = 4'd15;
   localparam int SOFT_RST_BIT = 31;

   typedef struct packed {
      logic [1:0] mux;
      logic       en;
      logic [7:0] div;
      logic [3:0] dly;
   } chan_cfg_t;

   typedef struct packed {
      logic        fout_en;
      logic        glob_en;
      logic        pdn;
      logic [3:0]  mode;
      logic [11:0] rdiv;
   } pll_ctl_t;

   typedef struct packed {
      logic [1:0]  cp;
      logic [3:0]  post;
      logic [17:0] ndiv;
   } loop_cfg_t;

   localparam chan_cfg_t CH_DEFAULT   = '{mux: 2'd0, en: 1'b0, div: 8'd1, dly: 4'd0};
   localparam pll_ctl_t  PLL_DEFAULT  = '{fout_en: 1'b0, glob_en: 1'b1, pdn: 1'b0,
                                          mode: 4'd0, rdiv: 12'd10};
   localparam loop_cfg_t LOOP_DEFAULT = '{cp: 2'd0, post: 4'd2, ndiv: 18'd760};
   localparam logic [7:0] REF_DEFAULT = 8'd10;

   localparam int CH_CFG_W = $bits(chan_cfg_t);

   function automatic chan_cfg_t chan_from_frame(input logic [FRAME_W-1:0] f);
      chan_cfg_t c;
      c.mux = f[18:17];
      c.en  = f[16];
      c.div = f[15:8];
      c.dly = f[7:4];
      return c;
   endfunction

   function automatic pll_ctl_t pll_from_frame(input logic [FRAME_W-1:0] f);
      pll_ctl_t p;
      p.fout_en = f[28];
      p.glob_en = f[27];
      p.pdn     = f[26];
      p.mode    = f[23:20];
      p.rdiv    = f[19:8];
      return p;
   endfunction

   function automatic loop_cfg_t loop_from_frame(input logic [FRAME_W-1:0] f);
      loop_cfg_t l;
      l.cp   = f[31:30];
      l.post = f[29:26];
      l.ndiv = f[25:8];
      return l;
   endfunction
endpackage

// File: rtl/cfgbank_sync.sv
`timescale 1ns/1ps
module cfgbank_sync #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("cfgbank_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stg [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[0] <= '0;
            else        stg[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[i] <= '0;
            else        stg[i] <= stg[i-1];
         end
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/cfgbank_shifter.sv
`timescale 1ns/1ps
module cfgbank_shifter
   import cfgbank_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sclk_s,
   input  logic               sdat_s,
   input  logic               le_s,
   output logic [FRAME_W-1:0] frame,
   output logic               shift_en,
   output logic               load
);
   logic sclk_d, le_d;

   assign shift_en = sclk_s && !sclk_d && !le_s;
   assign load     = le_s && !le_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d <= 1'b0;
         le_d   <= 1'b0;
         frame  <= '0;
      end else begin
         sclk_d <= sclk_s;
         le_d   <= le_s;
         if (shift_en) frame <= {frame[FRAME_W-2:0], sdat_s};
      end
   end
endmodule

// File: rtl/cfgbank_regs.sv
`timescale 1ns/1ps
module cfgbank_regs
   import cfgbank_pkg::*;
#(
   parameter int NUM_CH  = 4,
   parameter int CH_BASE = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     load,
   input  logic [FRAME_W-1:0]       frame,
   output chan_cfg_t [NUM_CH-1:0]   chans,
   output logic [7:0]               ref_mhz,
   output pll_ctl_t                 pll,
   output loop_cfg_t                loop_cfg,
   output logic                     cal_start
);
   logic [ADDR_W-1:0] addr;
   logic soft_rst, we_ref, we_pll, we_loop;
   logic upd_loop_q, cal_q;

   assign addr     = frame[ADDR_W-1:0];
   assign soft_rst = load && (addr == ADR_CTRL) && frame[SOFT_RST_BIT];
   assign we_ref   = load && (addr == ADR_REF);
   assign we_pll   = load && (addr == ADR_PLL);
   assign we_loop  = load && (addr == ADR_LOOP);

   for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
      localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(CH_BASE + k);
      chan_cfg_t q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                         q <= CH_DEFAULT;
         else if (soft_rst)                  q <= CH_DEFAULT;
         else if (load && addr == MY_ADDR)   q <= chan_from_frame(frame);
      end
      assign chans[k] = q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ref_mhz  <= REF_DEFAULT;
         pll      <= PLL_DEFAULT;
         loop_cfg <= LOOP_DEFAULT;
      end else if (soft_rst) begin
         ref_mhz  <= REF_DEFAULT;
         pll      <= PLL_DEFAULT;
         loop_cfg <= LOOP_DEFAULT;
      end else begin
         if (we_ref)  ref_mhz  <= frame[21:14];
         if (we_pll)  pll      <= pll_from_frame(frame);
         if (we_loop) loop_cfg <= loop_from_frame(frame);
      end
   end

   // calibration start trails the register 15 update by one cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         upd_loop_q <= 1'b0;
         cal_q      <= 1'b0;
      end else begin
         upd_loop_q <= we_loop;
         cal_q      <= upd_loop_q;
      end
   end

   assign cal_start = cal_q;
endmodule

// File: rtl/cfg_serial_bank.sv
`timescale 1ns/1ps
module cfg_serial_bank
   import cfgbank_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int NUM_CH      = 4,
   parameter int CH_BASE     = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  ser_clk,
   input  logic                  ser_data,
   input  logic                  ser_le,
   output logic [2*NUM_CH-1:0]   ch_mux,
   output logic [NUM_CH-1:0]     ch_en,
   output logic [8*NUM_CH-1:0]   ch_div,
   output logic [4*NUM_CH-1:0]   ch_dly,
   output logic [7:0]            ref_mhz,
   output logic                  fout_en,
   output logic                  glob_out_en,
   output logic                  power_down,
   output logic [3:0]            status_mode,
   output logic [11:0]           r_div,
   output logic [1:0]            cp_gain,
   output logic [3:0]            post_div,
   output logic [17:0]           n_div,
   output logic                  cal_start
);
   localparam int CFG_W = NUM_CH * CH_CFG_W + 8 + $bits(pll_ctl_t) + $bits(loop_cfg_t);

   if (NUM_CH < 1 || CH_BASE < 1 || CH_BASE + NUM_CH > int'(ADR_REF)) begin : g_bad_map
      $error("cfg_serial_bank: channel addresses must lie between 1 and 12");
   end

   logic [2:0]         raw_in, sync_out;
   logic [FRAME_W-1:0] frame_word;
   logic               shift_en, load_pulse;
   chan_cfg_t [NUM_CH-1:0] chans;
   pll_ctl_t           pll;
   loop_cfg_t          loop_cfg;

   assign raw_in = {ser_le, ser_data, ser_clk};

   cfgbank_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(raw_in), .q(sync_out)
   );

   cfgbank_shifter u_shift (
      .clk(clk), .rst_n(rst_n),
      .sclk_s(sync_out[0]), .sdat_s(sync_out[1]), .le_s(sync_out[2]),
      .frame(frame_word), .shift_en(shift_en), .load(load_pulse)
   );

   cfgbank_regs #(.NUM_CH(NUM_CH), .CH_BASE(CH_BASE)) u_regs (
      .clk(clk), .rst_n(rst_n), .load(load_pulse), .frame(frame_word),
      .chans(chans), .ref_mhz(ref_mhz), .pll(pll), .loop_cfg(loop_cfg),
      .cal_start(cal_start)
   );

   for (genvar k = 0; k < NUM_CH; k++) begin : g_flat
      assign ch_mux[2*k +: 2] = chans[k].mux;
      assign ch_en[k]         = chans[k].en;
      assign ch_div[8*k +: 8] = chans[k].div;
      assign ch_dly[4*k +: 4] = chans[k].dly;
   end

   assign fout_en     = pll.fout_en;
   assign glob_out_en = pll.glob_en;
   assign power_down  = pll.pdn;
   assign status_mode = pll.mode;
   assign r_div       = pll.rdiv;
   assign cp_gain     = loop_cfg.cp;
   assign post_div    = loop_cfg.post;
   assign n_div       = loop_cfg.ndiv;
endmodule

// File: rtl/cfgbank_chk.sv
`timescale 1ns/1ps
module cfgbank_chk
   import cfgbank_pkg::*;
#(
   parameter int CFG_W   = 8,
   parameter int NUM_CH  = 4,
   parameter int CH_BASE = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               shift_en,
   input logic               load,
   input logic [FRAME_W-1:0] frame,
   input logic [CFG_W-1:0]   cfg,
   input logic               glob_out_en,
   input logic [11:0]        r_div,
   input logic [17:0]        n_div,
   input logic [7:0]         ref_mhz,
   input logic               cal_start
);
   logic [ADDR_W-1:0] a;
   logic holds_fields, loop_wr;

   assign a = frame[ADDR_W-1:0];
   assign holds_fields = (a == ADR_CTRL && frame[SOFT_RST_BIT]) || a == ADR_REF ||
                         a == ADR_PLL || a == ADR_LOOP ||
                         (int'(a) >= CH_BASE && int'(a) < CH_BASE + NUM_CH);
   assign loop_wr = load && (a == ADR_LOOP);

   // R1: one bit enters per qualified serial clock edge
   a_r1_one_bit_per_edge: assert property (@(posedge clk) disable iff (!rst_n)
      shift_en |=> frame[FRAME_W-1:1] == $past(frame[FRAME_W-2:0]));

   // R6: calibration pulse is one cycle wide
   a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      cal_start |=> !cal_start);

   // R6: calibration pulse only follows a register 15 commit
   a_r6_follows_loop_write: assert property (@(posedge clk) disable iff (!rst_n)
      cal_start |-> $past(loop_wr, 2));

   // R7: soft reset restores defaults
   a_r7_soft_reset_defaults: assert property (@(posedge clk) disable iff (!rst_n)
      (load && a == ADR_CTRL && frame[SOFT_RST_BIT]) |=>
         (glob_out_en && r_div == PLL_DEFAULT.rdiv && n_div == LOOP_DEFAULT.ndiv &&
          ref_mhz == REF_DEFAULT));

   // R8: commits to empty addresses change nothing
   a_r8_empty_addr_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !holds_fields) |=> $stable(cfg));
endmodule

bind cfg_serial_bank cfgbank_chk #(.CFG_W(CFG_W), .NUM_CH(NUM_CH), .CH_BASE(CH_BASE)) u_chk (
   .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .load(load_pulse), .frame(frame_word),
   .cfg({chans, ref_mhz, pll, loop_cfg}), .glob_out_en(glob_out_en), .r_div(r_div),
   .n_div(n_div), .ref_mhz(ref_mhz), .cal_start(cal_start)
);

// File: tb/cfg_serial_bank_test.sv
`timescale 1ns/1ps
module cfg_serial_bank_test;
   localparam int NCH  = 4;
   localparam int BASE = 4;
   localparam int HALF = 8;
   localparam int NVEC = 9;
   localparam logic [31:0] VEC [NVEC] = '{
      (32'd3 << 17) | (32'd1 << 16) | (32'h05 << 8) | (32'hA << 4) | 32'd4,
      (32'd1 << 17) | (32'd0 << 16) | (32'hFF << 8) | (32'hF << 4) | 32'd7,
      (32'd200 << 14) | 32'd13,
      (32'd1 << 28) | (32'd1 << 26) | (32'hB << 20) | (32'hFFF << 8) | 32'd14,
      (32'd3 << 30) | (32'd5 << 26) | (32'h3FFFF << 8) | 32'd15,
      32'hFFFF_FFF9,
      32'hFFFF_FFF8,
      32'h7FFF_FFF0,
      (32'd3 << 30) | (32'd5 << 26) | (32'h3FFFF << 8) | 32'd15
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic ser_clk = 1'b0, ser_data = 1'b0, ser_le = 1'b0;
   logic [2*NCH-1:0] ch_mux;
   logic [NCH-1:0]   ch_en;
   logic [8*NCH-1:0] ch_div;
   logic [4*NCH-1:0] ch_dly;
   logic [7:0]  ref_mhz;
   logic        fout_en, glob_out_en, power_down, cal_start;
   logic [3:0]  status_mode, post_div;
   logic [11:0] r_div;
   logic [1:0]  cp_gain;
   logic [17:0] n_div;

   int n_chk = 0, n_bad = 0, cal_seen = 0;
   bit done = 0;

   // bench model of the register bank
   logic [14:0] m_ch [NCH];
   logic [7:0]  m_ref;
   logic [18:0] m_pll;
   logic [23:0] m_loop;
   int          m_cal;

   always #2.5 clk = ~clk;

   cfg_serial_bank #(.SYNC_STAGES(3), .NUM_CH(NCH), .CH_BASE(BASE)) uut (
      .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data), .ser_le(ser_le),
      .ch_mux(ch_mux), .ch_en(ch_en), .ch_div(ch_div), .ch_dly(ch_dly), .ref_mhz(ref_mhz),
      .fout_en(fout_en), .glob_out_en(glob_out_en), .power_down(power_down),
      .status_mode(status_mode), .r_div(r_div), .cp_gain(cp_gain), .post_div(post_div),
      .n_div(n_div), .cal_start(cal_start)
   );

   always @(posedge clk) if (cal_start) cal_seen++;

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic model_defaults();
      for (int k = 0; k < NCH; k++) m_ch[k] = {2'd0, 1'b0, 8'd1, 4'd0};
      m_ref = 8'd10;
      m_pll = {1'b0, 1'b1, 1'b0, 4'd0, 12'd10};
      m_loop = {2'd0, 4'd2, 18'd760};
   endtask

   task automatic model_commit(input logic [31:0] w);
      int a = int'(w[3:0]);
      m_cal = 0;
      if (a == 0 && w[31]) model_defaults();
      else if (a >= BASE && a < BASE + NCH) m_ch[a-BASE] = w[18:4];
      else if (a == 13) m_ref = w[21:14];
      else if (a == 14) m_pll = {w[28:26], w[23:8]};
      else if (a == 15) begin m_loop = w[31:8]; m_cal = 1; end
   endtask

   function automatic string tag_for(input logic [31:0] w);
      int a = int'(w[3:0]);
      if (a == 0) return "R7";
      if (a >= BASE && a < BASE + NCH) return "R2";
      if (a == 13) return "R3";
      if (a == 14) return "R4";
      if (a == 15) return "R5";
      return "R8";
   endfunction

   task automatic compare_all(input string req);
      for (int k = 0; k < NCH; k++)
         check(req, {ch_mux[2*k +: 2], ch_en[k], ch_div[8*k +: 8], ch_dly[4*k +: 4]}, m_ch[k]);
      check(req, ref_mhz, m_ref);
      check(req, {fout_en, glob_out_en, power_down, status_mode, r_div}, m_pll);
      check(req, {cp_gain, post_div, n_div}, m_loop);
   endtask

   task automatic shift_bits(input logic [31:0] w, input int n);
      for (int i = n - 1; i >= 0; i--) begin
         ser_data = w[i];
         repeat (HALF) @(negedge clk);
         ser_clk = 1'b1;
         repeat (HALF) @(negedge clk);
         ser_clk = 1'b0;
      end
   endtask

   task automatic latch_frame();
      cal_seen = 0;
      repeat (HALF) @(negedge clk);
      ser_le = 1'b1;
      repeat (12) @(negedge clk);
      ser_le = 1'b0;
      repeat (12) @(negedge clk);
   endtask

   initial begin
      #(5ns * 150000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] prev, part;
      model_defaults();
      repeat (6) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      // R9: reset state
      compare_all("R9");
      check("R9 cal_start", cal_start, 1'b0);

      // table walk: R1 transport plus field decode per address
      for (int v = 0; v < NVEC; v++) begin
         shift_bits(VEC[v], 32);
         latch_frame();
         model_commit(VEC[v]);
         compare_all(tag_for(VEC[v]));
         check("R6 pulse count", cal_seen, m_cal);
      end

      // R6: second identical register 15 write above also pulsed; R1 edges under high latch shift nothing
      ser_le = 1'b1;
      repeat (12) @(negedge clk);
      shift_bits(32'hFFFF_FFFF, 8);
      ser_le = 1'b0;
      repeat (12) @(negedge clk);
      prev = (32'd2 << 17) | (32'd1 << 16) | (32'h33 << 8) | (32'h7 << 4) | 32'd5;
      shift_bits(prev, 32);
      latch_frame();
      model_commit(prev);
      compare_all("R1");

      // R10: short frame reuses the older bits
      shift_bits(32'h0000_0096, 8);
      latch_frame();
      part = {prev[23:0], 8'h96};
      model_commit(part);
      compare_all("R10");
      check("R10 no pulse", cal_seen, 0);

      // R7: soft reset with junk bits
      shift_bits(32'h8ABC_DEF0, 32);
      latch_frame();
      model_commit(32'h8ABC_DEF0);
      compare_all("R7");
      check("R7 no pulse", cal_seen, 0);

      // R9: hard reset after changes
      shift_bits(VEC[4], 32);
      latch_frame();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      model_defaults();
      compare_all("R9");

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule